// File: doc/BRIEF.md
# Per-CPU Interval Tick Skip Counter Bank

This block keeps one down-counter for each of four processors so that software can let a chosen number of periodic timer ticks pass before a processor is interrupted. An external tick level is brought into the clock domain and edge-detected. Each rising edge of the tick makes every counter belonging to a present processor count down by one. The first time a counter wraps below zero, a sticky overflow flag is set. From then on each tick sends a one-cycle timer-set pulse to that processor, and the count keeps running down, so software can work out how many ticks were skipped.

Software loads a counter by writing a 24-bit value at that processor's register offset. The write also clears the overflow flag. Software reads the count and the flag back at the same offset. A counter whose processor is marked absent stays frozen.

Top module: `ivt_skip_bank`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, every counter reads zero with its overflow flag clear, and `timer_set` is all zero.
- R2: A cycle with `wr_en` high and `reg_addr` equal to 0x380, 0x3C0, 0x700 or 0x740 (processor 0, 1, 2 or 3 in that order) loads `wr_data` into that processor's count and clears its overflow flag. Any other address changes no counter.
- R3: `rd_data` carries the addressed processor's count in bits 23:0 and its overflow flag in bit 24, and `rd_hit` is 1. For an address outside the four offsets, `rd_data` is 0 and `rd_hit` is 0.
- R4: On a tick, a counter holding the 25-bit value V (overflow in bit 24) becomes ((V − 1) mod 2^25) OR (V AND 0x1000000). Once the overflow flag is set, it stays set until a write clears it.
- R5: When the overflow flag is set after a tick's decrement, `timer_set` for that processor is high for exactly one cycle. The pulse and the counter update both occur on the fourth rising `clk` edge after `tick_lvl` rises.
- R6: A processor whose `cpu_present` bit is 0 keeps its counter unchanged on ticks and receives no `timer_set` pulse.
- R7: Each rising edge of `tick_lvl` causes exactly one decrement, however long the level stays high. A falling edge causes none.
- R8: When a write to a processor's offset falls in the same cycle as that processor's tick update, the written value is stored, the overflow flag is cleared, and no pulse is produced for that processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_lvl | input | 1 | Asynchronous periodic tick level |
| cpu_present | input | 4 | One bit per processor; 1 means present |
| reg_addr | input | 12 | Register offset for both read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 24 | Count to load |
| rd_data | output | 25 | Overflow flag (bit 24) and count (bits 23:0) at `reg_addr` |
| rd_hit | output | 1 | `reg_addr` selects a counter |
| timer_set | output | 4 | One-cycle timer interrupt set pulse per processor |

## Verification
The assertions check four properties on every cycle: the overflow flag never falls without a write, absent processors hold their state, every pulse is backed by a set overflow flag on a present processor, and a write always overrides a same-cycle tick. The bench scenarios cover the rest. They show the exact decrement arithmetic across the wrap from zero, the four-edge latency from tick level to pulse, and that one long tick level yields a single decrement. They also show the read and write address decode, including addresses next to the four offsets.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int NCPU   = 4;
    localparam int CNT_W  = 24;
    localparam int ST_W   = CNT_W + 1;
    localparam int ADDR_W = 12;

    typedef logic [ADDR_W-1:0] reg_addr_t;

    typedef struct packed {
        logic             ovf;
        logic [CNT_W-1:0] cnt;
    } skip_state_t;

    // Register offset for each processor slot; the decoder depends on it.
    function automatic reg_addr_t slot_offset(input int idx);
        case (idx)
            0:       return reg_addr_t'(12'h380);
            1:       return reg_addr_t'(12'h3C0);
            2:       return reg_addr_t'(12'h700);
            default: return reg_addr_t'(12'h740);
        endcase
    endfunction

    // One tick: wrap-around decrement over the full 25 bits, overflow sticky.
    function automatic skip_state_t step_down(input skip_state_t cur);
        logic [ST_W-1:0] flat;
        logic [ST_W-1:0] dec;
        skip_state_t     nxt;
        flat    = cur;
        dec     = flat - 1'b1;
        nxt.cnt = dec[CNT_W-1:0];
        nxt.ovf = dec[CNT_W] | cur.ovf;
        return nxt;
    endfunction

    function automatic skip_state_t load_value(input logic [CNT_W-1:0] d);
        skip_state_t v;
        v.ovf = 1'b0;
        v.cnt = d;
        return v;
    endfunction
endpackage

// File: rtl/ivt_tick_edge.sv
module ivt_tick_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_lvl,
    output logic tick_pulse
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              pulse_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= tick_lvl;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], tick_lvl};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            prev_q  <= sync_q[TOP];
            pulse_q <= sync_q[TOP] & ~prev_q;
        end
    end

    assign tick_pulse = pulse_q;
endmodule

// File: rtl/ivt_reg_decode.sv
module ivt_reg_decode
    import ivt_pkg::*;
(
    input  reg_addr_t                 reg_addr,
    input  logic                      wr_en,
    input  skip_state_t [NCPU-1:0]    state,
    output logic [NCPU-1:0]           wr_hit,
    output logic [ST_W-1:0]           rd_data,
    output logic                      rd_hit
);
    logic [NCPU-1:0] sel;

    generate
        for (genvar gi = 0; gi < NCPU; gi++) begin : g_sel
            assign sel[gi] = (reg_addr == slot_offset(gi));
        end
    endgenerate

    assign wr_hit = sel & {NCPU{wr_en}};

    always_comb begin
        rd_data = '0;
        rd_hit  = 1'b0;
        for (int i = 0; i < NCPU; i++) begin
            if (sel[i]) begin
                rd_data = state[i];
                rd_hit  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ivt_skip_slot.sv
module ivt_skip_slot
    import ivt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             present,
    input  logic             tick,
    input  logic             wr_hit,
    input  logic [CNT_W-1:0] wr_data,
    output skip_state_t      state_q,
    output logic             set_q
);
    skip_state_t after_tick;

    assign after_tick = step_down(state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            set_q   <= 1'b0;
        end else begin
            set_q <= 1'b0;
            if (wr_hit) begin
                state_q <= load_value(wr_data);
            end else if (tick && present) begin
                state_q <= after_tick;
                set_q   <= after_tick.ovf;
            end
        end
    end
endmodule

// File: rtl/ivt_skip_bank.sv
module ivt_skip_bank
    import ivt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_lvl,
    input  logic [NCPU-1:0]   cpu_present,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [ST_W-1:0]   rd_data,
    output logic              rd_hit,
    output logic [NCPU-1:0]   timer_set
);
    logic                   tick_pulse;
    logic [NCPU-1:0]        wr_hit;
    skip_state_t [NCPU-1:0] slot_state;

    ivt_tick_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst        (rst),
        .tick_lvl   (tick_lvl),
        .tick_pulse (tick_pulse)
    );

    ivt_reg_decode u_dec (
        .reg_addr (reg_addr),
        .wr_en    (wr_en),
        .state    (slot_state),
        .wr_hit   (wr_hit),
        .rd_data  (rd_data),
        .rd_hit   (rd_hit)
    );

    generate
        for (genvar gi = 0; gi < NCPU; gi++) begin : g_slot
            ivt_skip_slot u_slot (
                .clk     (clk),
                .rst     (rst),
                .present (cpu_present[gi]),
                .tick    (tick_pulse),
                .wr_hit  (wr_hit[gi]),
                .wr_data (wr_data),
                .state_q (slot_state[gi]),
                .set_q   (timer_set[gi])
            );
        end
    endgenerate
endmodule

// File: rtl/ivt_skip_bank_chk.sv
module ivt_skip_bank_chk
    import ivt_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic [NCPU-1:0]        cpu_present,
    input logic [NCPU-1:0]        wr_hit,
    input logic [CNT_W-1:0]       wr_data,
    input skip_state_t [NCPU-1:0] state,
    input logic [NCPU-1:0]        timer_set
);
    // R1: reset leaves no pulse pending
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (timer_set == '0));

    generate
        for (genvar gi = 0; gi < NCPU; gi++) begin : g_cpu
            // R4: overflow flag only falls through a write
            assert_sticky_ovf_R4: assert property (@(posedge clk) disable iff (rst)
                (state[gi].ovf && !wr_hit[gi]) |=> state[gi].ovf);

            // R6: absent processor keeps its state
            assert_absent_hold_R6: assert property (@(posedge clk) disable iff (rst)
                (!cpu_present[gi] && !wr_hit[gi]) |=> (state[gi] == $past(state[gi])));

            // R5 and R6: pulse needs overflow and a present processor
            assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (rst)
                timer_set[gi] |-> (state[gi].ovf && $past(cpu_present[gi])));

            // R8: a write overrides any tick in the same cycle
            assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
                wr_hit[gi] |=> (state[gi].cnt == $past(wr_data) && !state[gi].ovf
                                && !timer_set[gi]));
        end
    endgenerate
endmodule

bind ivt_skip_bank ivt_skip_bank_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_present (cpu_present),
    .wr_hit      (wr_hit),
    .wr_data     (wr_data),
    .state       (slot_state),
    .timer_set   (timer_set)
);

// File: tb/ivt_skip_bank_test.sv
module ivt_skip_bank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_lvl = 1'b0;
    logic [3:0]  cpu_present = 4'hF;
    logic [11:0] reg_addr = 12'h000;
    logic        wr_en = 1'b0;
    logic [23:0] wr_data = '0;
    logic [24:0] rd_data;
    logic        rd_hit;
    logic [3:0]  timer_set;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [24:0] model [4];
    logic [3:0]  exp_q [$];
    logic [11:0] offs [4] = '{12'h380, 12'h3C0, 12'h700, 12'h740};

    always #5 clk = ~clk;

    ivt_skip_bank uut (
        .clk (clk), .rst (rst), .tick_lvl (tick_lvl), .cpu_present (cpu_present),
        .reg_addr (reg_addr), .wr_en (wr_en), .wr_data (wr_data),
        .rd_data (rd_data), .rd_hit (rd_hit), .timer_set (timer_set)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: every pulse pattern must match the next expected item.
    always @(negedge clk) begin
        if (!rst && !finished && timer_set != 4'h0) begin
            if (exp_q.size() == 0) begin
                check(0, "R5 unexpected pulse", 32'(timer_set), 32'h0);
            end else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                check(timer_set == e, "R5 pulse mask", 32'(timer_set), 32'(e));
            end
        end
    end

    function automatic logic [24:0] model_step(input logic [24:0] v);
        return ((v - 25'd1) & 25'h1FFFFFF) | (v & 25'h1000000);
    endfunction

    // Advances the model by one tick; skip_idx (or -1) marks a write that wins.
    task automatic push_tick(input int skip_idx);
        logic [3:0] m;
        m = 4'h0;
        for (int i = 0; i < 4; i++) begin
            if (cpu_present[i] && i != skip_idx) begin
                model[i] = model_step(model[i]);
                if (model[i][24]) m[i] = 1'b1;
            end
        end
        if (m != 4'h0) exp_q.push_back(m);
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [23:0] d);
        @(negedge clk);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        for (int i = 0; i < 4; i++) if (offs[i] == a) model[i] = {1'b0, d};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_check(input int idx, input string req);
        @(negedge clk);
        reg_addr = offs[idx];
        #1;
        check(rd_data == model[idx] && rd_hit, req, 32'(rd_data), 32'(model[idx]));
    endtask

    task automatic do_tick(input int hold);
        @(negedge clk);
        push_tick(-1);
        tick_lvl = 1'b1;
        repeat (hold) @(negedge clk);
        tick_lvl = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        // R1: state during reset
        check(timer_set == 4'h0, "R1 pulses in reset", 32'(timer_set), 32'h0);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) read_check(i, "R1 reset count");

        // R2, R3: loads and readback
        reg_write(12'h380, 24'd3);
        reg_write(12'h700, 24'd5);
        reg_write(12'h740, 24'd1);
        reg_write(12'h384, 24'hABCDEF);
        for (int i = 0; i < 4; i++) read_check(i, "R2 load and readback");
        @(negedge clk);
        reg_addr = 12'h384;
        #1;
        check(rd_data == '0 && !rd_hit, "R3 unmapped read", 32'(rd_data), 32'h0);

        // R4, R5: ticks, including the wrap from zero on processor 1
        do_tick(4);
        for (int i = 0; i < 4; i++) read_check(i, "R4 first tick");
        do_tick(4);
        for (int i = 0; i < 4; i++) read_check(i, "R4 sticky overflow");

        // R6: processors 1 and 3 absent
        cpu_present = 4'b0101;
        do_tick(4);
        for (int i = 0; i < 4; i++) read_check(i, "R6 absent frozen");
        cpu_present = 4'hF;

        // R7: long high level gives one decrement
        do_tick(20);
        for (int i = 0; i < 4; i++) read_check(i, "R7 single decrement");

        // R2: write clears overflow
        reg_write(12'h3C0, 24'd2);
        read_check(1, "R2 overflow cleared");

        // R8: write to processor 2 lands with the tick update (fourth edge)
        @(negedge clk);
        push_tick(2);
        tick_lvl = 1'b1;
        repeat (3) @(negedge clk);
        reg_addr = 12'h700; wr_data = 24'h00F00F; wr_en = 1'b1;
        model[2] = {1'b0, 24'h00F00F};
        @(negedge clk);
        wr_en = 1'b0;
        tick_lvl = 1'b0;
        repeat (5) @(negedge clk);
        for (int i = 0; i < 4; i++) read_check(i, "R8 write wins");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R5 missing pulse", 32'(exp_q.size()), 32'h0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule